// File: doc/BRIEF.md
# Two-Way Write-Back Data Cache

This block is a two-way set-associative data cache placed between a processor load/store port and a memory port that moves a wide beat per transfer. Each set holds two lines. Each line carries a valid bit, a dirty bit and a tag. An access uses its index field to pick a set and compares both stored tags against the request tag in the same cycle. A hit returns the addressed word combinationally, and a store that hits is written at the next clock edge.

On a miss the cache stalls the processor. The victim is the way of the set that was filled longest ago; each set keeps a single FIFO pointer for this. If that way is valid and dirty, its line goes out to memory first. The missing line is then brought in as a sequence of beats. Stores that miss allocate the line first and are then applied to the cached copy. Memory sees a write only when a dirty line is evicted.

The processor holds its request stable while `cpu_stall` is high. The memory side uses a request/acknowledge handshake that moves one beat per acknowledged cycle.

Top module: `cache_2way_wb`

## Requirements
- R1: After a synchronous active-low reset every line is invalid, every FIFO pointer selects way 0, `mem_req` is low, and the first access to any address misses without a write-back.
- R2: A byte address splits into word-in-line bits [5:2], index bits [9:6] (16 sets by default) and tag bits [31:10]. Two lines with the same index and different tags are held in the two ways at once, and lines with different indices never displace each other.
- R3: A read to a resident line gives `cpu_stall` low and the stored word on `cpu_rdata` in the same cycle.
- R4: A store hit updates byte i (bits 8i+7:8i) of the addressed word only where `cpu_be[i]` is 1. It leaves the other bytes unchanged, causes no memory traffic and finishes without a stall.
- R5: A store hit marks the line dirty, and memory is not updated at that time. When a dirty line is evicted, all four of its beats are written to memory before the read request for the new line is issued.
- R6: Evicting a clean or invalid way causes no memory write.
- R7: A store that misses first fills the line from memory. The store is then merged into the cached copy, and memory keeps its old value until that line is evicted.
- R8: The victim in a set is the way filled least recently. Each set's pointer toggles on every fill into that set, whatever hits occurred in between.
- R9: A refill moves 16-byte beats 0 to 3 in order, and beat k holds line bytes 16k to 16k+15. `mem_addr` carries the 64-byte-aligned address of the line with `mem_we` low for a refill and high for a write-back.
- R10: `cpu_stall` is high from the cycle a miss is seen until the cycle the requested word is available. With an acknowledge on every cycle this lasts 5 cycles for a clean miss and 9 cycles for a dirty miss.
- R11: Once raised, `mem_req`, `mem_we` and `mem_addr` hold until the fourth acknowledged beat. A beat moves only in a cycle where `mem_ack` is high, and `mem_addr` is always line-aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_req | input | 1 | Processor access valid |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address of the access |
| cpu_wdata | input | 32 | Store data |
| cpu_be | input | 4 | Store byte enables |
| cpu_rdata | output | 32 | Load data, valid when stall is low |
| cpu_stall | output | 1 | Request not yet served |
| mem_req | output | 1 | Line transfer in progress |
| mem_we | output | 1 | 1 = write-back, 0 = refill |
| mem_addr | output | 32 | Line-aligned memory address |
| mem_wdata | output | 128 | Write-back beat data |
| mem_ack | input | 1 | Beat accepted or delivered this cycle |
| mem_rdata | input | 128 | Refill beat data |

## Verification
The bench fills a line and touches it again before filling a third line into the same set. Under least-recently-used replacement the wrong way would survive, and a later hit or miss on the other line would show the error. A partial byte-enable store is followed by an eviction and a reload. This exposes a cache that drops the dirty bit, writes back the wrong beat, or merges the wrong bytes, because the reloaded word would not match. Exact stall lengths on clean and dirty misses catch a fill started before the write-back or a stall released one cycle early. A store miss then checks that memory stays untouched until eviction, which catches a write-through design.

// File: rtl/cache_pkg.sv
// Shared types for the two-way write-back cache.
// Assumes nothing beyond a single clock domain.
package cache_pkg;

    // Controller phases: lookup, dirty write-back, line refill.
    typedef enum logic [1:0] {
        ST_LOOK = 2'd0,
        ST_WB   = 2'd1,
        ST_FILL = 2'd2
    } ctl_state_e;

endpackage

// File: rtl/cache_tag_store.sv
// Tag, valid, dirty and FIFO-pointer state for a two-way cache.
// Compares both ways of the indexed set in parallel and reports the victim way.
// Assumes fill_en and dirty_en are never asserted in the same cycle.
module cache_tag_store #(
    parameter int TAG_W = 22,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             hit,
    output logic             hit_way,
    output logic             vict_way,
    output logic             vict_valid,
    output logic             vict_dirty,
    output logic [TAG_W-1:0] vict_tag,
    input  logic             fill_en,
    input  logic             dirty_en,
    input  logic             dirty_way
);
    localparam int SETS = 1 << IDX_W;

    logic [TAG_W-1:0] tag_q   [2][SETS];
    logic [SETS-1:0]  valid_q [2];
    logic [SETS-1:0]  dirty_q [2];
    logic [SETS-1:0]  ptr_q;
    logic [1:0]       match;

    // Parallel tag compare, one comparator per way.
    for (genvar w = 0; w < 2; w++) begin : g_cmp
        assign match[w] = valid_q[w][lk_idx] && (tag_q[w][lk_idx] == lk_tag);
    end

    // Hit and victim selection.
    always_comb begin
        hit        = |match;
        hit_way    = match[1];
        vict_way   = ptr_q[lk_idx];
        vict_valid = valid_q[vict_way][lk_idx];
        vict_dirty = dirty_q[vict_way][lk_idx];
        vict_tag   = tag_q[vict_way][lk_idx];
    end

    // Status bits and FIFO pointers, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q[0] <= '0;
            valid_q[1] <= '0;
            dirty_q[0] <= '0;
            dirty_q[1] <= '0;
            ptr_q      <= '0;
        end else if (fill_en) begin
            valid_q[vict_way][lk_idx] <= 1'b1;
            dirty_q[vict_way][lk_idx] <= 1'b0;
            ptr_q[lk_idx]             <= ~ptr_q[lk_idx];
        end else if (dirty_en) begin
            dirty_q[dirty_way][lk_idx] <= 1'b1;
        end
    end

    // Tag storage, written on fill only.
    always_ff @(posedge clk) begin
        if (fill_en) tag_q[vict_way][lk_idx] <= lk_tag;
    end

    AST_ONE_WAY_HITS: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(match) <= 1); // R2
    AST_FIFO_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> ptr_q[$past(lk_idx)] != $past(ptr_q[lk_idx])); // R8

endmodule

// File: rtl/cache_data_store.sv
// Line data for both ways. Word read for hits, byte-enabled word write for
// stores, beat write for refills and beat read for write-backs.
// Assumes beat writes and word writes are not requested together.
module cache_data_store #(
    parameter int IDX_W  = 4,
    parameter int LINE_W = 512,
    parameter int WORD_W = 32,
    parameter int BEAT_W = 128
) (
    input  logic                      clk,
    input  logic [IDX_W-1:0]          idx,
    input  logic                      rd_way,
    input  logic [$clog2(LINE_W/WORD_W)-1:0] word_sel,
    output logic [WORD_W-1:0]         rdata,
    input  logic                      wr_en,
    input  logic                      wr_way,
    input  logic [WORD_W-1:0]         wdata,
    input  logic [WORD_W/8-1:0]       be,
    input  logic                      beat_wr_en,
    input  logic                      beat_way,
    input  logic [$clog2(LINE_W/BEAT_W)-1:0] beat_sel,
    input  logic [BEAT_W-1:0]         beat_wdata,
    output logic [BEAT_W-1:0]         beat_rdata
);
    localparam int SETS = 1 << IDX_W;
    localparam int WB   = WORD_W / 8;

    logic [LINE_W-1:0] line_q [2*SETS];

    // Combinational word and beat read ports.
    always_comb begin
        rdata      = line_q[{rd_way, idx}][WORD_W*int'(word_sel) +: WORD_W];
        beat_rdata = line_q[{beat_way, idx}][BEAT_W*int'(beat_sel) +: BEAT_W];
    end

    // Refill beats and byte-enabled store writes.
    always_ff @(posedge clk) begin
        if (beat_wr_en) begin
            line_q[{beat_way, idx}][BEAT_W*int'(beat_sel) +: BEAT_W] <= beat_wdata;
        end else if (wr_en) begin
            for (int b = 0; b < WB; b++) begin
                if (be[b]) line_q[{wr_way, idx}][WORD_W*int'(word_sel) + 8*b +: 8] <= wdata[8*b +: 8];
            end
        end
    end

endmodule

// File: rtl/cache_ctrl.sv
// Miss sequencer: lookup, optional dirty write-back, then refill.
// Counts acknowledged beats. Assumes the processor request is stable while stalled.
module cache_ctrl
    import cache_pkg::*;
#(
    parameter int BCNT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              hit,
    input  logic              vict_valid,
    input  logic              vict_dirty,
    input  logic              mem_ack,
    output logic              mem_req,
    output logic              mem_we,
    output logic [BCNT_W-1:0] beat_cnt,
    output logic              fill_beat_en,
    output logic              fill_done,
    output logic              in_look
);
    ctl_state_e        state_q, state_d;
    logic [BCNT_W-1:0] cnt_q;
    logic              last_beat;

    // Decode outputs and the next state.
    always_comb begin
        in_look      = (state_q == ST_LOOK);
        mem_req      = !in_look;
        mem_we       = (state_q == ST_WB);
        beat_cnt     = cnt_q;
        last_beat    = mem_ack && (cnt_q == {BCNT_W{1'b1}});
        fill_beat_en = (state_q == ST_FILL) && mem_ack;
        fill_done    = fill_beat_en && last_beat;
        state_d      = state_q;
        case (state_q)
            ST_LOOK: if (cpu_req && !hit) state_d = (vict_valid && vict_dirty) ? ST_WB : ST_FILL;
            ST_WB:   if (last_beat) state_d = ST_FILL;
            ST_FILL: if (last_beat) state_d = ST_LOOK;
            default: state_d = ST_LOOK;
        endcase
    end

    // State and beat counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_LOOK;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (mem_req && mem_ack) cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_MISS_RAISES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        in_look && cpu_req && !hit |=> mem_req); // R10
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !last_beat |=> mem_req && $stable(mem_we)); // R11
    AST_WB_THEN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we && last_beat |=> mem_req && !mem_we); // R5

endmodule

// File: rtl/cache_2way_wb.sv
// Two-way set-associative write-back, write-allocate data cache with FIFO
// replacement. Hits serve in one cycle; misses stall the processor while a
// dirty victim is written back and the new line is refilled beat by beat.
// Assumes cpu_addr/cpu_we/cpu_wdata/cpu_be hold while cpu_stall is high.
module cache_2way_wb #(
    parameter int ADDR_W     = 32,
    parameter int WORD_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int BEAT_BYTES = 16,
    parameter int SETS       = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cpu_req,
    input  logic                    cpu_we,
    input  logic [ADDR_W-1:0]       cpu_addr,
    input  logic [WORD_W-1:0]       cpu_wdata,
    input  logic [WORD_W/8-1:0]     cpu_be,
    output logic [WORD_W-1:0]       cpu_rdata,
    output logic                    cpu_stall,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [BEAT_BYTES*8-1:0] mem_wdata,
    input  logic                    mem_ack,
    input  logic [BEAT_BYTES*8-1:0] mem_rdata
);
    localparam int BOFF_W = $clog2(WORD_W / 8);
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
    localparam int WSEL_W = OFF_W - BOFF_W;
    localparam int LINE_W = LINE_BYTES * 8;
    localparam int BEAT_W = BEAT_BYTES * 8;
    localparam int BCNT_W = $clog2(LINE_BYTES / BEAT_BYTES);

    logic [IDX_W-1:0]  idx;
    logic [TAG_W-1:0]  tag;
    logic [WSEL_W-1:0] wsel;
    logic              hit, hit_way, vict_way, vict_valid, vict_dirty;
    logic [TAG_W-1:0]  vict_tag;
    logic [BCNT_W-1:0] beat_cnt;
    logic              fill_beat_en, fill_done, in_look, store_hit;
    logic              unused_byte_lsb;

    // Address field split.
    assign idx             = cpu_addr[OFF_W +: IDX_W];
    assign tag             = cpu_addr[OFF_W+IDX_W +: TAG_W];
    assign wsel            = cpu_addr[BOFF_W +: WSEL_W];
    assign unused_byte_lsb = ^cpu_addr[BOFF_W-1:0];

    // Processor-side handshake and memory address selection.
    assign store_hit = in_look && cpu_req && cpu_we && hit;
    assign cpu_stall = !in_look || (cpu_req && !hit);
    assign mem_addr  = mem_we ? {vict_tag, idx, {OFF_W{1'b0}}} : {tag, idx, {OFF_W{1'b0}}};

    cache_tag_store #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_tags (
        .clk(clk), .rst_n(rst_n), .lk_idx(idx), .lk_tag(tag),
        .hit(hit), .hit_way(hit_way), .vict_way(vict_way),
        .vict_valid(vict_valid), .vict_dirty(vict_dirty), .vict_tag(vict_tag),
        .fill_en(fill_done), .dirty_en(store_hit), .dirty_way(hit_way)
    );

    cache_data_store #(.IDX_W(IDX_W), .LINE_W(LINE_W), .WORD_W(WORD_W), .BEAT_W(BEAT_W)) u_data (
        .clk(clk), .idx(idx), .rd_way(hit_way), .word_sel(wsel), .rdata(cpu_rdata),
        .wr_en(store_hit), .wr_way(hit_way), .wdata(cpu_wdata), .be(cpu_be),
        .beat_wr_en(fill_beat_en), .beat_way(vict_way), .beat_sel(beat_cnt),
        .beat_wdata(mem_rdata), .beat_rdata(mem_wdata)
    );

    cache_ctrl #(.BCNT_W(BCNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .hit(hit),
        .vict_valid(vict_valid), .vict_dirty(vict_dirty), .mem_ack(mem_ack),
        .mem_req(mem_req), .mem_we(mem_we), .beat_cnt(beat_cnt),
        .fill_beat_en(fill_beat_en), .fill_done(fill_done), .in_look(in_look)
    );

    AST_WB_ONLY_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> vict_valid && vict_dirty); // R6
    AST_NO_STORE_IN_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> cpu_stall); // R10

endmodule

// File: tb/tb_cache_2way_wb.sv
// Self-checking bench: memory responder model, golden word image, directed
// corner cases, then seeded random traffic with random acknowledge gaps.
module tb_cache_2way_wb;
    localparam int MEMW = 2048;

    logic         clk, rst_n, cpu_req, cpu_we, cpu_stall, mem_req, mem_we, mem_ack;
    logic [31:0]  cpu_addr, cpu_wdata, cpu_rdata, mem_addr;
    logic [3:0]   cpu_be;
    logic [127:0] mem_wdata, mem_rdata;

    int checks = 0, errors = 0;
    logic [31:0] mem_img [MEMW];
    logic [31:0] ref_img [MEMW];
    int wb_lines = 0, fill_lines = 0, bcnt = 0;
    logic [31:0] last_wb_addr, last_fill_addr;
    bit ack_rand = 0, seen_op = 0, first_we = 0;

    cache_2way_wb dut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_be(cpu_be), .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    initial begin
        clk = 0;
        forever #10 clk = ~clk;
    end

    function automatic logic [31:0] init_word(int w);
        return (w * 32'h9E3779B1) ^ 32'h5A5A0000;
    endfunction

    function automatic logic [31:0] merge(logic [31:0] old, logic [31:0] nw, logic [3:0] be);
        logic [31:0] r = old;
        for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = nw[8*b +: 8];
        return r;
    endfunction

    function automatic logic [31:0] mk(int tg, int ix, int wd);
        return (tg << 10) | (ix << 6) | (wd << 2);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Memory responder: one beat per acknowledged cycle, inputs driven at negedge.
    initial begin
        mem_ack = 0;
        mem_rdata = '0;
        forever begin
            @(negedge clk);
            if (mem_req) begin
                bit go;
                int ln;
                go = !ack_rand || ($urandom % 3 != 0);
                if (go) begin
                    check("R11 line-aligned mem_addr", {26'd0, mem_addr[5:0]}, 32'd0);
                    ln = int'(mem_addr[12:6]);
                    if (!seen_op) begin seen_op = 1; first_we = mem_we; end
                    for (int j = 0; j < 4; j++) begin
                        if (mem_we) mem_img[ln*16 + bcnt*4 + j] = mem_wdata[32*j +: 32];
                        else mem_rdata[32*j +: 32] = mem_img[ln*16 + bcnt*4 + j];
                    end
                    mem_ack = 1;
                    bcnt++;
                    if (bcnt == 4) begin
                        bcnt = 0;
                        if (mem_we) begin wb_lines++; last_wb_addr = mem_addr; end
                        else begin fill_lines++; last_fill_addr = mem_addr; end
                    end
                end else mem_ack = 0;
            end else mem_ack = 0;
        end
    end

    // One processor access; counts stalled cycles sampled mid-low-phase.
    task automatic access(input bit we, input logic [31:0] addr, input logic [31:0] wd,
                          input logic [3:0] be, output logic [31:0] rd, output int stalls);
        @(negedge clk);
        cpu_req = 1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd; cpu_be = be;
        stalls = 0;
        #5;
        while (cpu_stall) begin
            stalls++;
            @(negedge clk);
            #5;
        end
        rd = cpu_rdata;
        if (we) ref_img[addr >> 2] = merge(ref_img[addr >> 2], wd, be);
        @(posedge clk);
        #1;
        cpu_req = 0;
    endtask

    // Watchdog: a hung run ends as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual running expected done");
        report();
    end

    initial begin
        logic [31:0] rd, a, b, c, d, mrg;
        int st, f0, w0;
        for (int i = 0; i < MEMW; i++) begin mem_img[i] = init_word(i); ref_img[i] = init_word(i); end
        rst_n = 0; cpu_req = 0; cpu_we = 0; cpu_addr = 0; cpu_wdata = 0; cpu_be = 0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        check("R1 stall idle after reset", {31'd0, cpu_stall}, 32'd0);
        check("R1 mem_req low after reset", {31'd0, mem_req}, 32'd0);

        a = mk(1, 3, 2); b = mk(2, 3, 5); c = mk(3, 3, 0); d = mk(0, 7, 9);
        access(0, a, 0, 0, rd, st);
        check("R10 clean miss stall cycles", st, 5);
        check("R1 no write-back on cold miss", wb_lines, 0);
        check("R9 one refill", fill_lines, 1);
        check("R9 refill address", last_fill_addr, a & ~32'h3F);
        check("R3 read data after fill", rd, ref_img[a >> 2]);
        access(0, a, 0, 0, rd, st);
        check("R3 hit has no stall", st, 0);
        check("R3 hit data", rd, ref_img[a >> 2]);

        f0 = fill_lines; w0 = wb_lines;
        access(1, a, 32'hAABBCCDD, 4'b0101, rd, st);
        mrg = merge(init_word(a >> 2), 32'hAABBCCDD, 4'b0101);
        check("R4 store hit no stall", st, 0);
        check("R4 store hit no memory traffic", fill_lines + wb_lines, f0 + w0);
        access(0, a, 0, 0, rd, st);
        check("R4 byte-enable merge", rd, mrg);
        check("R5 memory untouched by store hit", mem_img[a >> 2], init_word(a >> 2));

        access(0, b, 0, 0, rd, st);
        check("R2 same-set second tag misses", st, 5);
        access(0, a, 0, 0, rd, st);
        check("R2 both ways resident", st, 0);

        seen_op = 0;
        access(0, c, 0, 0, rd, st);
        check("R10 dirty miss stall cycles", st, 9);
        check("R5 one write-back", wb_lines, w0 + 1);
        check("R5 write-back address", last_wb_addr, a & ~32'h3F);
        check("R5 write-back before refill", {31'd0, first_we}, 32'd1);
        check("R5 evicted data reached memory", mem_img[a >> 2], mrg);
        check("R9 refill data", rd, ref_img[c >> 2]);
        access(0, b, 0, 0, rd, st);
        check("R8 FIFO kept later fill", st, 0);
        w0 = wb_lines;
        access(0, a, 0, 0, rd, st);
        check("R8 FIFO evicted earliest fill", st, 5);
        check("R6 clean victim no write-back", wb_lines, w0);
        check("R5 reloaded dirty data", rd, mrg);

        f0 = fill_lines;
        access(1, d, 32'h01234567, 4'b1111, rd, st);
        check("R7 store miss stalls for fill", st, 5);
        check("R7 store miss fills line", fill_lines, f0 + 1);
        access(0, d, 0, 0, rd, st);
        check("R7 store applied after allocate", rd, 32'h01234567);
        check("R7 memory keeps old value", mem_img[d >> 2], init_word(d >> 2));

        access(0, mk(1, 4, 0), 0, 0, rd, st);
        access(0, mk(1, 5, 0), 0, 0, rd, st);
        access(0, mk(1, 4, 0), 0, 0, rd, st);
        check("R2 separate index not displaced", st, 0);

        ack_rand = 1;
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] ad;
            bit we;
            ad = mk($urandom % 4, ($urandom % 2) ? $urandom % 4 : $urandom % 16, $urandom % 16);
            we = $urandom % 2;
            if (we) access(1, ad, $urandom, 4'($urandom), rd, st);
            else begin
                access(0, ad, 0, 0, rd, st);
                check("R3 random read vs golden", rd, ref_img[ad >> 2]);
            end
        end
        report();
    end

endmodule